// File: doc/BRIEF.md
# Soft-Switched Tap Commutation Sequencer

This block sequences the gates of a two-tap AC chopper. Each main tap (upper and lower) and each auxiliary branch (resonant branch and inductor branch) is built from a pair of unidirectional devices. When a tap change is requested, the block looks at the sampled signs of the tap voltage and the load current and at the requested direction. From these it picks one of two commutation schedules. It then moves every gate through a fixed order of on and off events whose times are cycle counts taken from input ports. It never observes current, so every turn-off lands on a precomputed time rather than on a sensed zero crossing.

The resonant schedule rings a small LC branch so that the outgoing tap's current swings through zero twice. The ramp schedule inserts an inductor branch whose current ramps linearly while the outgoing tap's current falls. The block refuses soft commutation when the lower tap voltage is too small, and also when a second resonant commutation would follow a resonant one before its capacitor could discharge. In both cases it raises a one-cycle hand-off pulse for an external hard-switching path.

Top module: `tap_commutation_seq`

## Requirements
- R1: After reset both upper-tap devices are on (`gate_up` = 2'b11), every other gate is off, the upper tap is the active tap, and `busy`, `done` and `fallback` are low.
- R2: A request is accepted while idle when `dir_down` (1 = upper to lower, 0 = lower to upper) points away from the active tap. The resonant schedule is chosen when the signs of voltage, current and direction (each 1 = positive, `dir_down` = 1 = positive) multiply to a positive value. The ramp schedule is chosen when the product is negative.
- R3: In each device pair the index switched first, f, is 0 when the schedule is resonant with positive current or ramp with negative current, and 1 otherwise. The other index is s.
- R4: Resonant schedule, with t counted in cycles from the acceptance edge (t = 0), T = `t_res` and K = `t_kc`. At t = 0 both resonant-branch gates and incoming[f] turn on. Outgoing[f] turns off at T − floor(T/4). Outgoing[s] turns off at T. Incoming[s] turns on at T+K. Resonant-branch[f] turns off at T+K+floor(T/2). Resonant-branch[s] turns off at 2T+K, which ends the sequence. The inductor branch stays off. Timing requires T ≥ 4 and K ≥ 1.
- R5: Ramp schedule, with G = `t_guard`, H = `t_ramp_hi` and L = `t_ramp_lo`. At t = 0 outgoing[f] turns off and incoming[f] turns on. Inductor-branch[s] turns on at G. Outgoing[s] turns off at G+H. Incoming[s] turns on at 2G+H. Inductor-branch[s] turns off at 2G+H+L, which ends the sequence. The resonant branch stays off. All counts must be ≥ 1.
- R6: The timing inputs are captured at acceptance. Changing them during a sequence does not alter that sequence.
- R7: `busy` is high from the acceptance edge until the final event edge. On that edge `done` pulses for exactly one cycle and the active tap becomes the incoming tap.
- R8: Requests made while busy, or requests pointing toward the tap already active, are ignored and leave all outputs unchanged.
- R9: If `low_v_ok` is low when a request would be accepted, no gate changes, `busy` stays low, and `fallback` pulses for one cycle.
- R10: A resonant-schedule request made when the previously started sequence was resonant is not run. It raises `fallback` instead, so that a ramp sequence must come between two resonant ones.
- R11: Upper and lower devices with the same index are never on together, except incoming[f] beside outgoing[f] during a resonant sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Tap change request |
| dir_down | input | 1 | 1 = upper to lower, 0 = lower to upper |
| v_pos | input | 1 | Sampled tap voltage sign, 1 = positive |
| i_pos | input | 1 | Sampled load current sign, 1 = positive |
| low_v_ok | input | 1 | Lower tap voltage at least half its nominal peak |
| t_res | input | TW | Resonant period in cycles |
| t_kc | input | TW | Resonant hand-over delay in cycles |
| t_guard | input | TW | Ramp guard delay in cycles |
| t_ramp_hi | input | TW | First ramp time in cycles |
| t_ramp_lo | input | TW | Second ramp time in cycles |
| gate_up | output | 2 | Upper tap device gates |
| gate_lo | output | 2 | Lower tap device gates |
| gate_ax1 | output | 2 | Resonant branch device gates |
| gate_ax2 | output | 2 | Inductor branch device gates |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fallback | output | 1 | One-cycle hand-off pulse to hard switching |

## Verification
The bench covers all four sign pairings, so that both values of the first-switched index appear under each schedule. A design with the index mapping inverted would turn off the device that carries the current first, and its gate words would differ from the model in the very first cycle. The bench changes the period input in the middle of a sequence. A design that used the live inputs instead of the captured ones would stretch its sequence. It also fires a resonant request straight after a resonant sequence, checks an inhibited request, and sends requests while busy or toward the active tap. A design that broke any of these would start a sequence where the model stays idle.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic {SCHED_RAMP = 1'b0, SCHED_RES = 1'b1} sched_e;
    localparam int RES_EVENTS  = 5;
    localparam int RAMP_EVENTS = 4;
endpackage

// File: rtl/tcs_select.sv
module tcs_select
    import tcs_pkg::*;
(
    input  logic   v_pos,
    input  logic   i_pos,
    input  logic   dir_down,
    output sched_e sched,
    output logic   first
);
    // product of three signs is positive when an even count is negative
    assign sched = (v_pos ^ i_pos ^ dir_down) ? SCHED_RES : SCHED_RAMP;
    // device index switched first in each pair
    assign first = (sched == SCHED_RES) ^ i_pos;
endmodule

// File: rtl/tcs_plan.sv
module tcs_plan
    import tcs_pkg::*;
#(
    parameter int TW  = 16,
    parameter int SW  = 3,
    parameter int EW  = TW + 2,
    parameter int NEV = 1 << SW
) (
    input  sched_e          sched,
    input  logic [TW-1:0]   t_res,
    input  logic [TW-1:0]   t_kc,
    input  logic [TW-1:0]   t_guard,
    input  logic [TW-1:0]   t_hi,
    input  logic [TW-1:0]   t_lo,
    output logic [EW-1:0]   ev [NEV],
    output logic [SW-1:0]   last
);
    logic [EW-1:0] tr, tk, tg, th, tl;

    assign tr = EW'(t_res);
    assign tk = EW'(t_kc);
    assign tg = EW'(t_guard);
    assign th = EW'(t_hi);
    assign tl = EW'(t_lo);

    always_comb begin
        for (int k = 0; k < NEV; k++) ev[k] = '0;
        if (sched == SCHED_RES) begin
            ev[0] = tr - (tr >> 2);
            ev[1] = tr;
            ev[2] = tr + tk;
            ev[3] = tr + tk + (tr >> 1);
            ev[4] = tr + tr + tk;
            last  = SW'(RES_EVENTS - 1);
        end else begin
            ev[0] = tg;
            ev[1] = tg + th;
            ev[2] = tg + tg + th;
            ev[3] = tg + tg + th + tl;
            last  = SW'(RAMP_EVENTS - 1);
        end
    end
endmodule

// File: rtl/tap_commutation_seq.sv
module tap_commutation_seq
    import tcs_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          dir_down,
    input  logic          v_pos,
    input  logic          i_pos,
    input  logic          low_v_ok,
    input  logic [TW-1:0] t_res,
    input  logic [TW-1:0] t_kc,
    input  logic [TW-1:0] t_guard,
    input  logic [TW-1:0] t_ramp_hi,
    input  logic [TW-1:0] t_ramp_lo,
    output logic [1:0]    gate_up,
    output logic [1:0]    gate_lo,
    output logic [1:0]    gate_ax1,
    output logic [1:0]    gate_ax2,
    output logic          busy,
    output logic          done,
    output logic          fallback
);
    localparam int SW  = 3;
    localparam int EW  = TW + 2;
    localparam int NEV = 1 << SW;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          fb;
        logic          tap_lo;
        sched_e        sched;
        logic          fi;
        logic          last_res;
        logic [SW-1:0] step;
        logic [EW-1:0] cnt;
        logic [1:0]    up;
        logic [1:0]    lo;
        logic [1:0]    ax1;
        logic [1:0]    ax2;
        logic [TW-1:0] tr;
        logic [TW-1:0] tk;
        logic [TW-1:0] tg;
        logic [TW-1:0] th;
        logic [TW-1:0] tl;
    } state_t;

    state_t        st_d, st_q;
    sched_e        sel_sched;
    logic          sel_first;
    logic [EW-1:0] ev [NEV];
    logic [SW-1:0] ev_last;
    logic [1:0]    og, ng, a1, a2;
    logic          fi, se;
    logic          res_run;
    logic          last_res;

    tcs_select u_sel (
        .v_pos    (v_pos),
        .i_pos    (i_pos),
        .dir_down (dir_down),
        .sched    (sel_sched),
        .first    (sel_first)
    );

    tcs_plan #(.TW(TW), .SW(SW), .EW(EW), .NEV(NEV)) u_plan (
        .sched   (st_q.sched),
        .t_res   (st_q.tr),
        .t_kc    (st_q.tk),
        .t_guard (st_q.tg),
        .t_hi    (st_q.th),
        .t_lo    (st_q.tl),
        .ev      (ev),
        .last    (ev_last)
    );

    always_comb begin
        st_d    = st_q;
        st_d.done = 1'b0;
        st_d.fb   = 1'b0;
        og = st_q.tap_lo ? st_q.lo : st_q.up;
        ng = st_q.tap_lo ? st_q.up : st_q.lo;
        a1 = st_q.ax1;
        a2 = st_q.ax2;
        fi = st_q.fi;
        se = ~st_q.fi;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == ev[st_q.step]) begin
                st_d.step = st_q.step + 1'b1;
                if (st_q.sched == SCHED_RES) begin
                    case (st_q.step)
                        3'd0:    og[fi] = 1'b0;
                        3'd1:    og[se] = 1'b0;
                        3'd2:    ng[se] = 1'b1;
                        3'd3:    a1[fi] = 1'b0;
                        default: a1[se] = 1'b0;
                    endcase
                end else begin
                    case (st_q.step)
                        3'd0:    a2[se] = 1'b1;
                        3'd1:    og[se] = 1'b0;
                        3'd2:    ng[se] = 1'b1;
                        default: a2[se] = 1'b0;
                    endcase
                end
                if (st_q.step == ev_last) begin
                    st_d.busy   = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.tap_lo = ~st_q.tap_lo;
                end
            end
        end else if (req && (dir_down != st_q.tap_lo)) begin
            if (!low_v_ok || ((sel_sched == SCHED_RES) && st_q.last_res)) begin
                st_d.fb = 1'b1;
            end else begin
                st_d.busy     = 1'b1;
                st_d.sched    = sel_sched;
                st_d.fi       = sel_first;
                st_d.last_res = (sel_sched == SCHED_RES);
                st_d.step     = '0;
                st_d.cnt      = EW'(1);
                st_d.tr       = t_res;
                st_d.tk       = t_kc;
                st_d.tg       = t_guard;
                st_d.th       = t_ramp_hi;
                st_d.tl       = t_ramp_lo;
                ng[sel_first] = 1'b1;
                if (sel_sched == SCHED_RES) a1 = 2'b11;
                else                        og[sel_first] = 1'b0;
            end
        end
        st_d.up  = st_q.tap_lo ? ng : og;
        st_d.lo  = st_q.tap_lo ? og : ng;
        st_d.ax1 = a1;
        st_d.ax2 = a2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.up       <= 2'b11;
            st_q.sched    <= SCHED_RAMP;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_up  = st_q.up;
    assign gate_lo  = st_q.lo;
    assign gate_ax1 = st_q.ax1;
    assign gate_ax2 = st_q.ax2;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign fallback = st_q.fb;
    assign res_run  = (st_q.sched == SCHED_RES);
    assign last_res = st_q.last_res;
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] gate_up,
    input logic [1:0] gate_lo,
    input logic [1:0] gate_ax1,
    input logic [1:0] gate_ax2,
    input logic       busy,
    input logic       done,
    input logic       fallback,
    input logic       res_run,
    input logic       last_res
);
    // R11: same-index overlap only inside a resonant sequence, and at most one index
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && res_run) |-> ((gate_up & gate_lo) == 2'b00));
    a_r11_single_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_up & gate_lo) <= 1);
    // R7: done is a single-cycle pulse ending a busy period
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R9: fallback leaves gates untouched
    a_r9_fb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fallback |-> (!busy && $stable(gate_up) && $stable(gate_lo)));
    // R4 and R5: each schedule uses only its own auxiliary branch
    a_r4_no_ramp_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && res_run) |-> (gate_ax2 == 2'b00));
    a_r5_no_res_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_run) |-> (gate_ax1 == 2'b00));
    a_r7_aux_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((gate_ax1 == 2'b00) && (gate_ax2 == 2'b00)));
    // R10: a resonant sequence never directly follows another resonant one
    a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && res_run) |-> !$past(last_res));
endmodule

bind tap_commutation_seq tcs_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_up  (gate_up),
    .gate_lo  (gate_lo),
    .gate_ax1 (gate_ax1),
    .gate_ax2 (gate_ax2),
    .busy     (busy),
    .done     (done),
    .fallback (fallback),
    .res_run  (res_run),
    .last_res (last_res)
);

// File: tb/tap_commutation_seq_tb_top.sv
module tap_commutation_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        dir_down = 1'b0;
    logic        v_pos = 1'b1;
    logic        i_pos = 1'b1;
    logic        low_v_ok = 1'b1;
    logic [15:0] t_res = 16'd8;
    logic [15:0] t_kc = 16'd1;
    logic [15:0] t_guard = 16'd2;
    logic [15:0] t_ramp_hi = 16'd5;
    logic [15:0] t_ramp_lo = 16'd4;
    logic [1:0]  gate_up, gate_lo, gate_ax1, gate_ax2;
    logic        busy, done, fallback;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #10 clk = ~clk;

    tap_commutation_seq #(.TW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .dir_down(dir_down),
        .v_pos(v_pos), .i_pos(i_pos), .low_v_ok(low_v_ok),
        .t_res(t_res), .t_kc(t_kc), .t_guard(t_guard),
        .t_ramp_hi(t_ramp_hi), .t_ramp_lo(t_ramp_lo),
        .gate_up(gate_up), .gate_lo(gate_lo), .gate_ax1(gate_ax1), .gate_ax2(gate_ax2),
        .busy(busy), .done(done), .fallback(fallback)
    );

    // ---------------- behavioural reference model ----------------
    bit       m_busy, m_done, m_fb, m_tap, m_res, m_last;
    bit [1:0] m_up, m_lo, m_a1, m_a2;
    int       m_t, m_f, mT, mK, mG, mH, mL;

    task automatic timeline();
        bit [1:0] o, n, x1, x2;
        int s, fin;
        s = 1 - m_f;
        o = '0; n = '0; x1 = '0; x2 = '0;
        if (m_res) begin
            fin     = 2*mT + mK;
            o[m_f]  = m_t < (mT - mT/4);
            o[s]    = m_t < mT;
            n[m_f]  = 1'b1;
            n[s]    = m_t >= mT + mK;
            x1[m_f] = m_t < (mT + mK + mT/2);
            x1[s]   = m_t < fin;
        end else begin
            fin     = 2*mG + mH + mL;
            n[m_f]  = 1'b1;
            o[s]    = m_t < mG + mH;
            n[s]    = m_t >= 2*mG + mH;
            x2[s]   = (m_t >= mG) && (m_t < fin);
        end
        if (m_tap) begin m_lo = o; m_up = n; end
        else       begin m_up = o; m_lo = n; end
        m_a1 = x1; m_a2 = x2;
        if (m_t == fin) begin
            m_busy = 0; m_done = 1; m_tap = ~m_tap;
        end
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fb = 0; m_tap = 0; m_last = 0; m_res = 0;
            m_up = 2'b11; m_lo = 0; m_a1 = 0; m_a2 = 0;
        end else begin
            m_done = 0; m_fb = 0;
            if (m_busy) begin
                m_t++;
                timeline();
            end else if (req && (dir_down != m_tap)) begin
                int sg;
                sg = (v_pos ? 1 : -1) * (i_pos ? 1 : -1) * (dir_down ? 1 : -1);
                if (!low_v_ok || (sg > 0 && m_last)) begin
                    m_fb = 1;
                end else begin
                    m_res = sg > 0; m_last = m_res;
                    m_f = m_res ? (i_pos ? 0 : 1) : (i_pos ? 1 : 0);
                    mT = t_res; mK = t_kc; mG = t_guard; mH = t_ramp_hi; mL = t_ramp_lo;
                    m_t = 0; m_busy = 1;
                    timeline();
                end
            end
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            check({gate_up, gate_lo, gate_ax1, gate_ax2} == {m_up, m_lo, m_a1, m_a2},
                  "R3 R4 R5 R11", "gates", {gate_up, gate_lo, gate_ax1, gate_ax2},
                  {m_up, m_lo, m_a1, m_a2});
            check(busy == m_busy, "R7", "busy", busy, m_busy);
            check(done == m_done, "R7", "done", done, m_done);
            check(fallback == m_fb, "R9 R10", "fallback", fallback, m_fb);
        end
    end

    task automatic pulse_req(bit d, bit v, bit i);
        @(negedge clk);
        dir_down = d; v_pos = v; i_pos = i; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic count_busy(output int n, input bit poke);
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 3) begin t_res = 16'd20; req = 1'b1; dir_down = 1'b1; end
            if (poke && n == 4) req = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(gate_up == 2'b11 && gate_lo == 0 && gate_ax1 == 0 && gate_ax2 == 0 && !busy,
              "R1", "reset gates", {gate_up, gate_lo, gate_ax1, gate_ax2}, 8'hC0);

        // R8 request toward active tap ignored
        pulse_req(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check(!busy && gate_up == 2'b11, "R8", "toward-active ignored", busy, 0);

        // R9 inhibit
        low_v_ok = 1'b0;
        pulse_req(1'b1, 1'b1, 1'b1);
        check(fallback && !busy && gate_up == 2'b11, "R9", "inhibit", {fallback, busy}, 2'b10);
        low_v_ok = 1'b1;
        @(negedge clk);

        // R2 R3 R4 resonant down, v+ i+ : f = 0
        pulse_req(1'b1, 1'b1, 1'b1);
        check(gate_ax1 == 2'b11 && gate_ax2 == 2'b00, "R2", "resonant branch on", gate_ax1, 3);
        check(gate_lo == 2'b01, "R3", "incoming first index 0", gate_lo, 1);
        count_busy(n, 1'b1);
        check(n == 17, "R6", "resonant length with captured period", n, 17);
        check(gate_lo == 2'b11 && gate_up == 2'b00, "R4", "lower tap active", {gate_up, gate_lo}, 4'h3);
        t_res = 16'd8;

        // R10 resonant again right after resonant: up, v- i+
        pulse_req(1'b0, 1'b0, 1'b1);
        check(fallback && !busy, "R10", "second resonant refused", {fallback, busy}, 2'b10);
        @(negedge clk);

        // R2 R3 R5 ramp up, v+ i+ : f = 1
        pulse_req(1'b0, 1'b1, 1'b1);
        check(gate_ax1 == 0 && gate_ax2 == 0, "R2", "ramp branch idle at start", {gate_ax1, gate_ax2}, 0);
        check(gate_lo == 2'b01 && gate_up == 2'b10, "R3", "ramp first index 1", {gate_up, gate_lo}, 4'h9);
        count_busy(n, 1'b0);
        check(n == 13, "R5", "ramp length", n, 13);
        check(gate_up == 2'b11 && gate_lo == 2'b00, "R7", "upper tap active", {gate_up, gate_lo}, 4'hC);

        // R3 R4 resonant down, v- i- : f = 1, new timing
        t_res = 16'd12; t_kc = 16'd2;
        pulse_req(1'b1, 1'b0, 1'b0);
        check(gate_lo == 2'b10 && gate_up == 2'b11 && gate_ax1 == 2'b11, "R3", "resonant first index 1",
              {gate_up, gate_lo, gate_ax1}, 6'h3B);
        count_busy(n, 1'b0);
        check(n == 26, "R4", "resonant length", n, 26);

        // R5 ramp up, v- i- : f = 0
        t_guard = 16'd3; t_ramp_hi = 16'd4; t_ramp_lo = 16'd6;
        pulse_req(1'b0, 1'b0, 1'b0);
        check(gate_up == 2'b01 && gate_lo == 2'b10, "R3", "ramp first index 0", {gate_up, gate_lo}, 4'h6);
        count_busy(n, 1'b0);
        check(n == 16, "R5", "ramp length second", n, 16);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule